// File: doc/BRIEF.md
# Dual-Mode Limit Timer/Counter

This block is a tick-driven timer/counter that a processor reaches through a 32-bit register port. The port has a 32-byte window and a word index taken from address bits 4..2. A separate `tick` input pulses once for each 500 ns counting period. The block does not divide the clock itself.

In system mode the counter climbs toward a programmable limit. On reaching it, the counter wraps to zero and sets a sticky reached flag, and the interrupt output follows that flag. Reading the limit register returns the limit, acknowledges the interrupt and restarts the count.

In user mode the same registers show a wide free-running counter, split across two words. Software can halt and resume it, and no interrupt is ever raised.

Mode and run control are held in one four-state machine:
- `ST_SYS_HELD`: system mode, stop flag set. This is the reset state.
- `ST_SYS_FREE`: system mode, stop flag clear.
- `ST_USR_HALT`: user mode, halted.
- `ST_USR_RUN`: user mode, counting.

The machine has these transitions:
- **Mode-to-user** is a mode write with bit 0 = 1. It moves `ST_SYS_HELD`→`ST_USR_HALT` and `ST_SYS_FREE`→`ST_USR_RUN`.
- **Mode-to-system** is a mode write with bit 0 = 0. It moves `ST_USR_HALT`→`ST_SYS_HELD` and `ST_USR_RUN`→`ST_SYS_FREE`.
- **Halt** is a run-control write with bit 0 = 1, taken in `ST_USR_RUN`. It moves to `ST_USR_HALT`.
- **Resume** is a run-control write with bit 0 = 0, taken in `ST_USR_HALT`. It moves to `ST_USR_RUN`.

The system states only remember the stop flag. A run-control write while in a system state leaves the state unchanged.

Top module: `dual_mode_timer`

## Requirements
- R1: After reset the stored limit, count, reached flag and interrupt are zero, the mode is system (index 4 reads 0) and the stop flag reads 1 at index 3.
- R2: In system mode every cycle with `tick` high advances the count by one. Index 1 returns the count in bits 30..9, with bits 8..0 always zero.
- R3: The period in ticks is limit bits 30..9, where a stored limit of zero counts as 0x7FFFFFFF and a period of zero counts as one. When count+1 reaches the period, the count becomes zero, reached (index 1 bit 31) sets, and `irq` rises. Both reached and `irq` stay set while ticks continue.
- R4: A write to index 0 stores the limit and restarts the count at zero. The stored limit is 0x7FFFFFFF for a write of zero, and otherwise the written value with bit 31 cleared. A tick in the same cycle is dropped.
- R5: A write to index 2 stores the limit by the same rule and leaves the count running. A tick in that same cycle is compared against the limit held before the write.
- R6: In system mode a read of index 0 returns the stored limit (bit 31 zero). It also clears reached and `irq` and restarts the count, dropping any tick in that cycle.
- R7: In user mode `irq` stays low and the limit is ignored. The 53-bit count increments on each tick while running. Index 0 returns count bits 52..22 in bits 30..0, and index 1 returns count bits 22..0 in bits 31..9. Reads have no side effects.
- R8: In user mode a write to index 3 halts (bit 0 = 1) or resumes (bit 0 = 0) without losing or adding ticks, and index 3 reads the stop flag in bit 0. In system mode writes to index 3 are ignored.
- R9: A write to index 4 sets the mode from bit 0 (1 = user, 0 = system), and index 4 reads it back. A write that changes the mode clears the count and reached and drops that cycle's tick. A write that keeps the mode has no effect.
- R10: Indices 2, 5, 6 and 7 read as zero. Writes to indices 5..7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle pulse per 500 ns count period |
| bus_sel | input | 1 | Register access valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte address in the window; bits 4..2 pick the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed register (combinational) |
| irq | output | 1 | Interrupt, high while reached is set in system mode |

## Verification
A state machine in the wrong state shows up at index 3 or 4 on the very next read. It also shows up as ticks being counted or not counted on the following cycle.

A counter or reached flag that is off by one shows up at index 1 immediately, and `irq` rises a cycle early or late on the wrap. A missed acknowledge leaves `irq` high in the cycle after the index-0 read. The bench's model compares `bus_rdata` and `irq` on every clock, so any of these is caught within one cycle of the faulty state appearing.

// File: rtl/dmt_pkg.sv
package dmt_pkg;
    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 5;
    localparam int FRAC_W  = 9;
    localparam int LIM_W   = 31;
    localparam int LO_W    = LIM_W - FRAC_W;
    localparam int HI_W    = 31;
    localparam int CNT_W   = LO_W + HI_W;

    localparam logic [2:0] IDX_LIMIT      = 3'd0;
    localparam logic [2:0] IDX_COUNT      = 3'd1;
    localparam logic [2:0] IDX_LIMIT_KEEP = 3'd2;
    localparam logic [2:0] IDX_RUNCTL     = 3'd3;
    localparam logic [2:0] IDX_MODE       = 3'd4;

    typedef enum logic [1:0] {
        ST_SYS_HELD = 2'd0,
        ST_SYS_FREE = 2'd1,
        ST_USR_HALT = 2'd2,
        ST_USR_RUN  = 2'd3
    } tmode_e;
endpackage

// File: rtl/dmt_fsm.sv
module dmt_fsm
    import dmt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_mode,
    input  logic wr_runctl,
    input  logic wbit,
    output logic sys_mode,
    output logic halted,
    output logic count_en,
    output logic mode_flip
);
    tmode_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_SYS_HELD;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (wr_mode) begin
            unique case (state_q)
                ST_SYS_HELD: if (wbit)  state_d = ST_USR_HALT;
                ST_SYS_FREE: if (wbit)  state_d = ST_USR_RUN;
                ST_USR_HALT: if (!wbit) state_d = ST_SYS_HELD;
                ST_USR_RUN:  if (!wbit) state_d = ST_SYS_FREE;
                default:     state_d = ST_SYS_HELD;
            endcase
        end else if (wr_runctl) begin
            unique case (state_q)
                ST_USR_HALT, ST_USR_RUN: state_d = wbit ? ST_USR_HALT : ST_USR_RUN;
                default:                 state_d = state_q;
            endcase
        end
    end

    always_comb begin
        sys_mode = 1'b1;
        halted   = 1'b1;
        count_en = 1'b1;
        unique case (state_q)
            ST_SYS_HELD: begin sys_mode = 1'b1; halted = 1'b1; count_en = 1'b1; end
            ST_SYS_FREE: begin sys_mode = 1'b1; halted = 1'b0; count_en = 1'b1; end
            ST_USR_HALT: begin sys_mode = 1'b0; halted = 1'b1; count_en = 1'b0; end
            ST_USR_RUN:  begin sys_mode = 1'b0; halted = 1'b0; count_en = 1'b1; end
            default:     begin sys_mode = 1'b1; halted = 1'b1; count_en = 1'b1; end
        endcase
        mode_flip = wr_mode && (wbit == sys_mode);
    end
endmodule

// File: rtl/dmt_count.sv
module dmt_count
    import dmt_pkg::*;
#(
    parameter int P_DATA_W = DATA_W,
    parameter int P_LIM_W  = LIM_W,
    parameter int P_FRAC_W = FRAC_W,
    parameter int P_CNT_W  = CNT_W,
    localparam int P_LO_W  = P_LIM_W - P_FRAC_W
)(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic                count_en,
    input  logic                sys_mode,
    input  logic                wr_lim,
    input  logic [P_DATA_W-1:0] lim_wdata,
    input  logic                restart,
    input  logic                clr_reached,
    output logic [P_LIM_W-1:0]  limit_q,
    output logic [P_CNT_W-1:0]  cnt_q,
    output logic                reached_q
);
    logic [P_LIM_W-1:0] lim_norm, lim_eff;
    logic [P_LO_W-1:0]  period;
    logic [P_LO_W:0]    lo_next;
    logic               hit;

    always_comb begin
        lim_norm = (lim_wdata == '0) ? {P_LIM_W{1'b1}} : lim_wdata[P_LIM_W-1:0];
        lim_eff  = (limit_q == '0) ? {P_LIM_W{1'b1}} : limit_q;
        period   = lim_eff[P_LIM_W-1:P_FRAC_W];
        if (period == '0) period = {{(P_LO_W-1){1'b0}}, 1'b1};
        lo_next  = {1'b0, cnt_q[P_LO_W-1:0]} + 1'b1;
        hit      = lo_next >= {1'b0, period};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            limit_q   <= '0;
            cnt_q     <= '0;
            reached_q <= 1'b0;
        end else begin
            if (wr_lim)      limit_q   <= lim_norm;
            if (clr_reached) reached_q <= 1'b0;
            if (restart) begin
                cnt_q <= '0;
            end else if (tick && count_en) begin
                if (sys_mode) begin
                    if (hit) begin
                        cnt_q     <= '0;
                        reached_q <= 1'b1;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/dmt_regif.sv
module dmt_regif
    import dmt_pkg::*;
#(
    parameter int P_DATA_W = DATA_W,
    parameter int P_ADDR_W = ADDR_W,
    parameter int P_LIM_W  = LIM_W,
    parameter int P_FRAC_W = FRAC_W,
    parameter int P_CNT_W  = CNT_W,
    localparam int P_LO_W  = P_LIM_W - P_FRAC_W
)(
    input  logic                bus_sel,
    input  logic                bus_we,
    input  logic [P_ADDR_W-1:0] bus_addr,
    input  logic                sys_mode,
    input  logic                halted,
    input  logic [P_LIM_W-1:0]  limit_q,
    input  logic [P_CNT_W-1:0]  cnt_q,
    input  logic                reached_q,
    output logic [P_DATA_W-1:0] bus_rdata,
    output logic                wr_lim,
    output logic                wr_lim_rst,
    output logic                wr_runctl,
    output logic                wr_mode,
    output logic                rd_ack
);
    logic [2:0] idx;
    logic       wr;

    always_comb begin
        idx        = bus_addr[P_ADDR_W-1:2];
        wr         = bus_sel && bus_we;
        wr_lim_rst = wr && (idx == IDX_LIMIT);
        wr_lim     = wr_lim_rst || (wr && (idx == IDX_LIMIT_KEEP));
        wr_runctl  = wr && (idx == IDX_RUNCTL);
        wr_mode    = wr && (idx == IDX_MODE);
        rd_ack     = bus_sel && !bus_we && (idx == IDX_LIMIT) && sys_mode;

        bus_rdata = '0;
        case (idx)
            IDX_LIMIT:
                bus_rdata = sys_mode ? {{(P_DATA_W-P_LIM_W){1'b0}}, limit_q}
                                     : {1'b0, cnt_q[P_CNT_W-1:P_LO_W]};
            IDX_COUNT:
                bus_rdata = sys_mode ? {reached_q, cnt_q[P_LO_W-1:0], {P_FRAC_W{1'b0}}}
                                     : {cnt_q[P_LO_W:0], {P_FRAC_W{1'b0}}};
            IDX_RUNCTL: bus_rdata = {{(P_DATA_W-1){1'b0}}, halted};
            IDX_MODE:   bus_rdata = {{(P_DATA_W-1){1'b0}}, !sys_mode};
            default:    bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/dual_mode_timer.sv
module dual_mode_timer
    import dmt_pkg::*;
#(
    parameter int P_DATA_W = DATA_W,
    parameter int P_ADDR_W = ADDR_W,
    parameter int P_LIM_W  = LIM_W,
    parameter int P_FRAC_W = FRAC_W,
    parameter int P_CNT_W  = CNT_W
)(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic                bus_sel,
    input  logic                bus_we,
    input  logic [P_ADDR_W-1:0] bus_addr,
    input  logic [P_DATA_W-1:0] bus_wdata,
    output logic [P_DATA_W-1:0] bus_rdata,
    output logic                irq
);
    logic                sys_mode, halted, count_en, mode_flip;
    logic                wr_lim, wr_lim_rst, wr_runctl, wr_mode, rd_ack;
    logic [P_LIM_W-1:0]  limit_q;
    logic [P_CNT_W-1:0]  cnt_q;
    logic                reached_q;

    dmt_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_mode   (wr_mode),
        .wr_runctl (wr_runctl),
        .wbit      (bus_wdata[0]),
        .sys_mode  (sys_mode),
        .halted    (halted),
        .count_en  (count_en),
        .mode_flip (mode_flip)
    );

    dmt_count #(
        .P_DATA_W (P_DATA_W), .P_LIM_W (P_LIM_W),
        .P_FRAC_W (P_FRAC_W), .P_CNT_W (P_CNT_W)
    ) u_count (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (tick),
        .count_en    (count_en),
        .sys_mode    (sys_mode),
        .wr_lim      (wr_lim),
        .lim_wdata   (bus_wdata),
        .restart     (wr_lim_rst || rd_ack || mode_flip),
        .clr_reached (rd_ack || mode_flip),
        .limit_q     (limit_q),
        .cnt_q       (cnt_q),
        .reached_q   (reached_q)
    );

    dmt_regif #(
        .P_DATA_W (P_DATA_W), .P_ADDR_W (P_ADDR_W), .P_LIM_W (P_LIM_W),
        .P_FRAC_W (P_FRAC_W), .P_CNT_W (P_CNT_W)
    ) u_regif (
        .bus_sel    (bus_sel),
        .bus_we     (bus_we),
        .bus_addr   (bus_addr),
        .sys_mode   (sys_mode),
        .halted     (halted),
        .limit_q    (limit_q),
        .cnt_q      (cnt_q),
        .reached_q  (reached_q),
        .bus_rdata  (bus_rdata),
        .wr_lim     (wr_lim),
        .wr_lim_rst (wr_lim_rst),
        .wr_runctl  (wr_runctl),
        .wr_mode    (wr_mode),
        .rd_ack     (rd_ack)
    );

    assign irq = reached_q;
endmodule

// File: rtl/dmt_checker.sv
module dmt_checker #(
    parameter int P_DATA_W = 32,
    parameter int P_ADDR_W = 5,
    parameter int P_CNT_W  = 53
)(
    input logic                clk,
    input logic                rst_n,
    input logic                bus_sel,
    input logic                bus_we,
    input logic [P_ADDR_W-1:0] bus_addr,
    input logic [P_DATA_W-1:0] bus_rdata,
    input logic                irq,
    input logic                sys_mode,
    input logic                halted,
    input logic [P_CNT_W-1:0]  cnt_q
);
    assert_low_bits_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr[P_ADDR_W-1:2] == 3'd1) |-> (bus_rdata[8:0] == 9'd0));

    assert_restart_on_limit_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_we && bus_addr[P_ADDR_W-1:2] == 3'd0) |=> (cnt_q == '0));

    assert_ack_clears_irq_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_we && bus_addr[P_ADDR_W-1:2] == 3'd0 && sys_mode)
        |=> (!irq && cnt_q == '0));

    assert_no_irq_in_user_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> sys_mode);

    assert_halt_freezes_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!sys_mode && halted && !(bus_sel && bus_we)) |=> $stable(cnt_q));

    assert_unused_reads_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr[P_ADDR_W-1:2] >= 3'd5) |-> (bus_rdata == '0));
endmodule

bind dual_mode_timer dmt_checker #(
    .P_DATA_W (P_DATA_W), .P_ADDR_W (P_ADDR_W), .P_CNT_W (P_CNT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .irq       (irq),
    .sys_mode  (sys_mode),
    .halted    (halted),
    .cnt_q     (cnt_q)
);

// File: tb/dual_mode_timer_bench.sv
module dual_mode_timer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    bit [31:0] m_limit;
    bit [63:0] m_cnt;
    bit        m_reached, m_user, m_stop;
    localparam bit [63:0] CMASK = (64'd1 << 53) - 64'd1;

    always #10 clk = ~clk;

    dual_mode_timer u_dual_mode_timer (
        .clk (clk), .rst_n (rst_n), .tick (tick), .bus_sel (bus_sel),
        .bus_we (bus_we), .bus_addr (bus_addr), .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata), .irq (irq)
    );

    function automatic bit [31:0] norm(bit [31:0] v);
        return (v == 0) ? 32'h7fff_ffff : (v & 32'h7fff_ffff);
    endfunction

    function automatic bit [31:0] exp_rd(bit [2:0] idx);
        case (idx)
            3'd0: return m_user ? 32'((m_cnt >> 22) & 64'h7fff_ffff) : m_limit;
            3'd1: return m_user ? 32'((m_cnt << 9) & 64'hffff_ffff)
                                : ({m_reached, 31'd0} | 32'(m_cnt << 9));
            3'd3: return {31'd0, m_stop};
            3'd4: return {31'd0, m_user};
            default: return 32'd0;
        endcase
    endfunction

    task automatic model_step();
        bit [2:0]  idx = bus_addr[4:2];
        bit [31:0] old_lim = m_limit;
        bit        old_stop = m_stop;
        bit        old_user = m_user;
        bit        rst_cnt = 0;
        bit [63:0] per;
        if (bus_sel && bus_we) begin
            case (idx)
                3'd0: begin m_limit = norm(bus_wdata); m_cnt = 0; rst_cnt = 1; end
                3'd2: m_limit = norm(bus_wdata);
                3'd3: if (m_user) m_stop = bus_wdata[0];
                3'd4: if (bus_wdata[0] != m_user) begin
                          m_user = bus_wdata[0]; m_cnt = 0; m_reached = 0; rst_cnt = 1;
                      end
                default: ;
            endcase
        end
        if (bus_sel && !bus_we && idx == 3'd0 && !m_user) begin
            m_cnt = 0; m_reached = 0; rst_cnt = 1;
        end
        if (tick && !rst_cnt) begin
            if (!old_user) begin
                per = 64'(((old_lim == 0) ? 32'h7fff_ffff : old_lim) >> 9);
                if (per == 0) per = 1;
                if (m_cnt + 1 >= per) begin m_cnt = 0; m_reached = 1; end
                else m_cnt = m_cnt + 1;
            end else if (!old_stop) begin
                m_cnt = (m_cnt + 1) & CMASK;
            end
        end
    endtask

    // drive at negedge, compare mid-cycle, advance model, wait for the edge
    task automatic cyc(string tag, bit sel, bit we, bit [4:0] addr, bit [31:0] wd, bit tk);
        bit [31:0] er;
        bus_sel = sel; bus_we = we; bus_addr = addr; bus_wdata = wd; tick = tk;
        #5;
        er = exp_rd(addr[4:2]);
        n_checks++;
        if (bus_rdata !== er || irq !== m_reached) begin
            n_fail++;
            $display("FAIL %s: rdata=%h irq=%b expected rdata=%h irq=%b",
                     tag, bus_rdata, irq, er, m_reached);
        end
        model_step();
        @(negedge clk);
    endtask

    task automatic rd(string tag, int idx, bit tk);  cyc(tag, 1, 0, 5'(idx << 2), 0, tk); endtask
    task automatic wr(string tag, int idx, bit [31:0] v, bit tk); cyc(tag, 1, 1, 5'(idx << 2), v, tk); endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_limit = 0; m_cnt = 0; m_reached = 0; m_user = 0; m_stop = 1;
        // R1 reset state
        rd("R1", 1, 0); rd("R1", 3, 0); rd("R1", 4, 0); rd("R1", 0, 0);
        // R4 limit write rules and restart with dropped tick
        wr("R4", 0, 32'h0, 1);           rd("R4", 1, 0);
        rd("R4", 0, 0);
        wr("R4", 0, 32'h8000_0000, 0);   rd("R4", 0, 0);
        wr("R4", 0, 32'hffff_fa00, 1);   rd("R4", 0, 0);
        wr("R4", 0, 32'h0000_0a00, 1);   rd("R4", 1, 0);
        // R2 counting, idle cycles hold
        for (int i = 0; i < 3; i++) begin rd("R2", 1, 1); rd("R2", 1, 0); end
        // R3 wrap at period 5, sticky reached
        for (int i = 0; i < 8; i++) rd("R3", 1, 1);
        // R6 acknowledge by reading the limit, with a dropped tick
        rd("R6", 0, 1); rd("R6", 1, 0);
        // R5 keep-count limit change
        rd("R5", 1, 1); rd("R5", 1, 1); rd("R5", 1, 1);
        wr("R5", 2, 32'h0000_0400, 1);  rd("R5", 1, 0); rd("R5", 2, 1); rd("R5", 1, 1);
        // R3 tiny limit gives period one
        wr("R3", 0, 32'h0000_0100, 0);
        for (int i = 0; i < 3; i++) rd("R3", 1, 1);
        rd("R6", 0, 0);
        // R10 unused indices
        for (int i = 5; i < 8; i++) begin wr("R10", i, 32'hffff_ffff, 1); rd("R10", i, 0); end
        rd("R10", 0, 0); rd("R10", 3, 0); rd("R10", 4, 0);
        // R8 run control ignored in system mode
        wr("R8", 3, 32'h0, 0); rd("R8", 3, 0);
        // R9 to user mode, starts halted
        wr("R0", 0, 32'h0000_0a00, 0);
        rd("R9", 1, 1); wr("R9", 4, 32'h1, 1); rd("R9", 4, 0);
        // R8 halted: ticks ignored, then resume
        rd("R8", 1, 1); rd("R8", 3, 1);
        wr("R8", 3, 32'h0, 1); rd("R8", 3, 0);
        // R7 free run past the limit, no irq, no side effect on index 0 reads
        for (int i = 0; i < 12; i++) rd("R7", (i % 2), 1);
        wr("R8", 3, 32'h1, 1);
        for (int i = 0; i < 4; i++) rd("R8", 1, 1);
        wr("R8", 3, 32'h0, 1); rd("R8", 1, 1); rd("R8", 1, 0);
        // R9 same-mode write has no effect, then back to system
        wr("R9", 4, 32'h1, 1); rd("R9", 1, 0);
        wr("R9", 4, 32'h0, 1); rd("R9", 1, 0); rd("R9", 3, 0); rd("R9", 4, 0);
        wr("R9", 4, 32'h0, 1); rd("R9", 1, 1);
        // mixed traffic, compared each clock
        for (int i = 0; i < 4000; i++) begin
            bit sel = ($urandom_range(0, 9) < 3);
            bit we  = $urandom_range(0, 1);
            bit [4:0] a = 5'($urandom_range(0, 31));
            bit [31:0] d;
            if (a[4:2] == 3'd0 || a[4:2] == 3'd2)
                d = ($urandom_range(0, 12) << 9) | $urandom_range(0, 511) | ($urandom_range(0, 1) << 31);
            else
                d = $urandom;
            cyc("R2", sel, we, a, d, $urandom_range(0, 1));
        end
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        #(20 * 150000);
        if (!finished) begin
            finished = 1;
            n_checks++; n_fail++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule